// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses of a small microcontroller core in a fixed ring of eight hardware entries. The core pushes the program counter when it calls a subroutine and when it enters an interrupt; the interrupt entry then continues at vector 0x0004. It pops the saved address when the subroutine returns and when the interrupt handler returns. The instruction decoder and the program-counter update logic sit outside the block and drive its two strobes.

Software cannot see the stack pointer, and the block has no overflow or underflow flag. The pointer is a counter that wraps in both directions. A push at full depth writes over the oldest saved address. A pop past empty hands back whatever stale entry the wrap reaches. The top entry is read combinationally, so the address that a pop removes is already on the output during the pop cycle.

Top module: `ret_addr_stack`

## Requirements
- R1: Eight pushes followed by eight pops return the pushed addresses in reverse order. The return order is last in, first out, at every depth from 1 to 8.
- R2: After a clock edge with push_i high and pop_i low, tos_o equals the push_addr_i value sampled at that edge.
- R3: During a cycle with pop_i high and push_i low, tos_o already shows the address being removed. After the edge, tos_o shows the entry pushed before it.
- R4: Pushes beyond eight levels overwrite the oldest entries and raise no error. After nine pushes v0..v8, eight pops yield v8 down to v1, and v0 is lost.
- R5: Pops past the bottom wrap modulo 8. They return the stale contents of the ring in descending slot order and raise no error.
- R6: A cycle with both push_i and pop_i high replaces the top entry with push_addr_i and leaves the depth unchanged. The next pop exposes the same entry that was below the old top.
- R7: Reset sets the internal pointer to slot 0 and leaves the entry contents as they were. After reset, tos_o shows ring slot 7, and the first push lands in slot 0.
- R8: A cycle with neither strobe high changes neither tos_o nor the internal pointer. The push_addr_i value in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the pointer |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| push_addr_i | input | 13 | Return address to save |
| pop_i | input | 1 | Pop strobe (return or return-from-interrupt) |
| tos_o | output | 13 | Current top-of-stack address, combinational |

## Verification
The bench builds the block with its default values: an 8-entry ring of 13-bit addresses. At this size, a sweep of every nesting depth from one to eight is short enough to run in full. The same holds for runs past both ends of the ring, which show every slot being overwritten and every wrap of the pointer in each direction. Because the ring is this small, a reset taken mid-stack can be checked against a slot whose contents the bench knows exactly.

// File: rtl/rastk_pkg.sv
package rastk_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_SWAP = 2'b11
  } stk_op_e;

  // Combine the two strobes into one operation code.
  function automatic stk_op_e op_of(input logic push, input logic pop);
    return stk_op_e'({push, pop});
  endfunction

  // Pointer value after an operation, wrapping modulo depth both ways.
  function automatic int unsigned ptr_after(input int unsigned sp,
                                            input stk_op_e op,
                                            input int unsigned depth);
    case (op)
      OP_PUSH: return (sp + 1) % depth;
      OP_POP:  return (sp + depth - 1) % depth;
      default: return sp;
    endcase
  endfunction

  // Slot that holds the top entry for a given pointer.
  function automatic int unsigned top_of(input int unsigned sp,
                                         input int unsigned depth);
    return (sp + depth - 1) % depth;
  endfunction

endpackage

// File: rtl/rastk_ptr.sv
module rastk_ptr
  import rastk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  output logic [PTR_W-1:0] sp_q,
  output logic [PTR_W-1:0] top_idx
);

  logic [PTR_W-1:0] sp_d;

  always_comb begin
    sp_d    = PTR_W'(ptr_after(32'(sp_q), op, DEPTH));
    top_idx = PTR_W'(top_of(32'(sp_q), DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

endmodule

// File: rtl/rastk_file.sv
module rastk_file #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 13,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [ADDR_W-1:0] rdata
);

  logic [ADDR_W-1:0] slot_q [DEPTH];

  // Entries carry no reset: contents survive a pointer reset.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && waddr == PTR_W'(g)) slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import rastk_pkg::*;
#(
  parameter int DEPTH  = 8,   // power of two
  parameter int ADDR_W = 13,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] tos_o
);

  stk_op_e          stk_op;
  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] top_idx;
  logic [PTR_W-1:0] wr_idx;
  logic             wr_en;

  assign stk_op = op_of(push_i, pop_i);
  assign wr_en  = push_i;
  // A combined push and pop rewrites the top slot in place.
  assign wr_idx = (stk_op == OP_SWAP) ? top_idx : sp_q;

  rastk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (stk_op),
    .sp_q    (sp_q),
    .top_idx (top_idx)
  );

  rastk_file #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_file (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (push_addr_i),
    .raddr (top_idx),
    .rdata (tos_o)
  );

endmodule

// File: rtl/rastk_chk.sv
module rastk_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 13,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic [ADDR_W-1:0] push_addr_i,
  input logic              pop_i,
  input logic [ADDR_W-1:0] tos_o,
  input logic [PTR_W-1:0]  sp_q
);

  localparam logic [PTR_W-1:0] STEP = PTR_W'(1);

  // R2: a plain push is on top after the edge
  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> tos_o == $past(push_addr_i));

  // R4: a plain push advances the pointer by one, wrapping at the ring end
  p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> PTR_W'(sp_q - $past(sp_q)) == STEP);

  // R5: a plain pop moves the pointer back by one, wrapping below zero
  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> PTR_W'($past(sp_q) - sp_q) == STEP);

  // R6: push with pop replaces the top and keeps the depth
  p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> (tos_o == $past(push_addr_i)) && $stable(sp_q));

  // R8: idle cycles disturb nothing
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(tos_o) && $stable(sp_q));

  // R7: reset returns the pointer to slot 0
  p_reset_ptr_r7: assert property (@(posedge clk)
    !rst_n |=> sp_q == '0);

endmodule

bind ret_addr_stack rastk_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_i      (push_i),
  .push_addr_i (push_addr_i),
  .pop_i       (pop_i),
  .tos_o       (tos_o),
  .sp_q        (sp_q)
);

// File: tb/tb_ret_addr_stack.sv
module tb_ret_addr_stack;

  localparam int D = 8;
  localparam int W = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         push_i = 1'b0;
  logic         pop_i = 1'b0;
  logic [W-1:0] push_addr_i = '0;
  logic [W-1:0] tos_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench view of the ring: pointer, contents, and which slots are known.
  int           msp = 0;
  logic [W-1:0] mmem [D];
  bit           mknown [D];

  ret_addr_stack dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_addr_i (push_addr_i),
    .pop_i       (pop_i),
    .tos_o       (tos_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: tos_o=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int top_slot();
    return (msp + D - 1) % D;
  endfunction

  // Apply one cycle of strobes, then compare tos_o to the bench view.
  task automatic op(input bit p, input bit q, input logic [W-1:0] a,
                    input string req);
    @(negedge clk);
    push_i = p; pop_i = q; push_addr_i = a;
    @(posedge clk);
    if (p && q) begin
      mmem[top_slot()] = a; mknown[top_slot()] = 1'b1;
    end else if (p) begin
      mmem[msp] = a; mknown[msp] = 1'b1; msp = (msp + 1) % D;
    end else if (q) begin
      msp = (msp + D - 1) % D;
    end
    #2;
    if (mknown[top_slot()]) chk(req, tos_o, mmem[top_slot()]);
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    msp = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [W-1:0] val(input int k);
    return W'(13'h0A5 + k * 211);
  endfunction

  initial begin
    for (int i = 0; i < D; i++) mknown[i] = 1'b0;
    do_reset();

    // R1, R2, R3: every depth from 1 to 8, pushed then unwound
    for (int d = 1; d <= D; d++) begin
      for (int i = 0; i < d; i++) op(1, 0, val(d * 16 + i), "R2");
      for (int i = 0; i < d; i++) begin
        chk("R3", tos_o, mmem[top_slot()]);   // popped value already out
        op(0, 1, val(999), "R1");
      end
    end

    // R6: replace at each depth, then unwind
    for (int i = 0; i < 4; i++) op(1, 0, val(300 + i), "R2");
    for (int k = 0; k < 3; k++) begin
      op(1, 1, val(400 + k), "R6");
      op(0, 1, val(0), "R6");
    end
    op(0, 1, val(0), "R3");

    // R8: idle cycles with changing address input
    op(1, 0, val(500), "R2");
    for (int i = 0; i < 4; i++) op(0, 0, val(600 + i), "R8");

    // R4: twelve pushes overrun the ring, then unwind twelve
    for (int i = 0; i < 12; i++) op(1, 0, val(700 + i), "R4");
    for (int i = 0; i < 12; i++) op(0, 1, val(0), (i < 8) ? "R4" : "R5");

    // R7: fill ring, push three more, reset mid-stack
    for (int i = 0; i < D; i++) op(1, 0, val(800 + i), "R2");
    for (int i = 0; i < 3; i++) op(1, 0, val(900 + i), "R2");
    do_reset();
    #1;
    chk("R7", tos_o, mmem[D-1]);
    op(1, 0, val(950), "R7");
    chk("R7", tos_o, val(950));
    op(0, 1, val(0), "R7");

    // R5: pop past empty, walking the stale ring downward
    for (int i = 0; i < 10; i++) op(0, 1, val(0), "R5");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule